// File: doc/BRIEF.md
# Two-Dimensional DMA Request Queue with Early-End Reporting

This block is the control and status front end of a two-dimensional DMA engine. Software programs a transfer through a 32-bit register port: source and destination addresses, row length and row count (each stored as the value minus one), per-side strides, and three flag bits. It then writes the start register. The block gives the request the next free 5-bit transfer ID and holds it in a one-entry slot until the data mover takes it. The ID stays outstanding until the mover reports that transfer finished.

The mover reports each transfer as either complete or ended early, with a byte count. Every report sets the done bit of that ID and raises a sticky end-of-transfer interrupt. An early end on a request that had reporting enabled also stores the pair (ID, byte count) in a four-entry queue. Software reads the queue through two registers. A flag in the done register shows that the queue holds data. If the queue is full, another reportable early end is held back at the mover interface until software frees a place.

Software can discover the build options by writing a register and reading it back. The low bits of the row length that cannot be cleared read back as ones. An address register reads back zero when its side has no memory-mapped master. The repeat flag reads back zero when repeat support is not built in. The register map is on a 4-byte stride. Registers used here: 0x410 interrupt pending, 0x414 interrupt enable, 0x420 ID status, 0x424 start, 0x428 flags, 0x42C destination address, 0x430 source address, 0x434 row length, 0x438 row count, 0x43C destination stride, 0x440 source stride, 0x444 done, 0x44C early-end length, 0x450 early-end ID.

Top module: `dreq_ctl`

## Requirements
- R1: After reset, no request is presented, `irq` is low, the next ID is 0, and all done, pending, enable, flags, address, stride and row-count registers read 0. The row-length register reads the alignment mask.
- R2: A write to 0x424 with bit 0 set captures the programmed registers into the request slot under the next ID, which then advances modulo 32. The write is ignored when the slot is occupied or the next ID is still outstanding. 0x424 bit 0 reads 1 in exactly those two cases. 0x420 bits 4:0 show the next ID.
- R3: `req_valid` and all request fields hold steady until `req_ready` is seen high. An ID stays outstanding from capture until a report for it is accepted.
- R4: An accepted report sets the done bit of its ID: 0x444 bit i for IDs 0..30, and 0x420 bit 16 for ID 31. Writing 1 to those bits clears them. A report in the same cycle wins over the clear.
- R5: An accepted early end on a request captured with flag bit 2 set appends (ID, length) to the early-end queue. 0x44C shows the head length and 0x450 the head ID, both 0 when the queue is empty. A read of 0x450 removes the head. Entries leave in arrival order.
- R6: 0x444 bit 31 reads 1 exactly while the early-end queue is not empty.
- R7: While the queue holds 4 entries, `cpl_ready` is low for an early end on a request with reporting enabled. It stays high for every other report.
- R8: An early end on a request captured with flag bit 2 clear adds no queue entry.
- R9: The flags register keeps bits 2:0 (bit 0 repeat, bit 1 last segment, bit 2 early-end reporting). Bit 0 reads back 0 when repeat support is not built in.
- R10: The row-length register reads back the written value with the low `LEN_ALIGN` bits forced to 1 and bits at and above `LEN_W` reading 0. The row count is masked to `LEN_W` bits.
- R11: An address register reads back what was written when its side is memory-mapped, and 0 otherwise.
- R12: Every accepted report sets the pending bit (0x410 bit 0, write 1 to clear, set wins over clear). `irq` is high exactly when the pending bit and the enable bit (0x414 bit 0) are both 1.
- R13: Offsets outside the map, and addresses that are not word-aligned, read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue on 0x450) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| req_valid | output | 1 | Request slot holds a request |
| req_ready | input | 1 | Mover takes the request |
| req_id | output | 5 | Transfer ID of the request |
| req_src | output | 32 | Source address |
| req_dst | output | 32 | Destination address |
| req_xlen | output | 32 | Row length minus one |
| req_ylen | output | 32 | Row count minus one |
| req_src_stride | output | 32 | Source stride |
| req_dst_stride | output | 32 | Destination stride |
| req_flags | output | 3 | Repeat, last, report-enable flags |
| cpl_valid | input | 1 | Mover presents a report |
| cpl_ready | output | 1 | Report accepted this cycle when valid |
| cpl_id | input | 5 | ID of the reported transfer |
| cpl_early | input | 1 | Transfer ended early |
| cpl_len | input | 32 | Bytes moved for an early end |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench drives the block with several kinds of pattern. A start that the mover holds off for several cycles shows whether the slot keeps its contents and refuses a second start. Four reportable early ends in a row fill the queue, and a fifth shows the stall. Between them, a normal report and an unflagged early end show that `cpl_ready` stalls only reportable early ends. Thirty-two starts without any report wrap the ID counter and show that the ID still outstanding blocks reuse. Readbacks of zero and all-ones separate forced-one, masked and dropped register bits.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int ID_W     = 5;
    localparam int NUM_ID   = 1 << ID_W;
    localparam int ADDR_W   = 12;
    localparam int FLAG_W   = 3;

    localparam int FLG_REPEAT = 0;
    localparam int FLG_LAST   = 1;
    localparam int FLG_REPORT = 2;

    localparam int STAT_DONE_TOP_BIT = 16;
    localparam int DONE_QNZ_BIT      = 31;

    localparam logic [ADDR_W-1:0] OFS_IRQ_PEND = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_ID_STAT  = 12'h420;
    localparam logic [ADDR_W-1:0] OFS_START    = 12'h424;
    localparam logic [ADDR_W-1:0] OFS_FLAGS    = 12'h428;
    localparam logic [ADDR_W-1:0] OFS_DST      = 12'h42C;
    localparam logic [ADDR_W-1:0] OFS_SRC      = 12'h430;
    localparam logic [ADDR_W-1:0] OFS_XLEN     = 12'h434;
    localparam logic [ADDR_W-1:0] OFS_YLEN     = 12'h438;
    localparam logic [ADDR_W-1:0] OFS_DSTRIDE  = 12'h43C;
    localparam logic [ADDR_W-1:0] OFS_SSTRIDE  = 12'h440;
    localparam logic [ADDR_W-1:0] OFS_DONE     = 12'h444;
    localparam logic [ADDR_W-1:0] OFS_ELEN     = 12'h44C;
    localparam logic [ADDR_W-1:0] OFS_EID      = 12'h450;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_IRQ_PEND, SEL_IRQ_EN, SEL_ID_STAT, SEL_START,
        SEL_FLAGS, SEL_DST, SEL_SRC, SEL_XLEN, SEL_YLEN,
        SEL_DSTRIDE, SEL_SSTRIDE, SEL_DONE, SEL_ELEN, SEL_EID
    } reg_sel_e;

    typedef struct packed {
        logic [31:0]       src;
        logic [31:0]       dst;
        logic [31:0]       xlen;
        logic [31:0]       ylen;
        logic [31:0]       src_stride;
        logic [31:0]       dst_stride;
        logic [FLAG_W-1:0] flags;
    } xfer_req_t;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic [31:0]     len;
    } early_rec_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_IRQ_PEND: return SEL_IRQ_PEND;
            OFS_IRQ_EN:   return SEL_IRQ_EN;
            OFS_ID_STAT:  return SEL_ID_STAT;
            OFS_START:    return SEL_START;
            OFS_FLAGS:    return SEL_FLAGS;
            OFS_DST:      return SEL_DST;
            OFS_SRC:      return SEL_SRC;
            OFS_XLEN:     return SEL_XLEN;
            OFS_YLEN:     return SEL_YLEN;
            OFS_DSTRIDE:  return SEL_DSTRIDE;
            OFS_SSTRIDE:  return SEL_SSTRIDE;
            OFS_DONE:     return SEL_DONE;
            OFS_ELEN:     return SEL_ELEN;
            OFS_EID:      return SEL_EID;
            default:      return SEL_NONE;
        endcase
    endfunction

    function automatic logic [ID_W-1:0] id_next(input logic [ID_W-1:0] v);
        return v + 1'b1;
    endfunction

endpackage

// File: rtl/dreq_cfg.sv
module dreq_cfg
    import dreq_pkg::*;
#(
    parameter bit HAS_REPEAT = 1'b1,
    parameter bit SRC_MM     = 1'b1,
    parameter bit DST_MM     = 1'b0,
    parameter int LEN_W      = 24,
    parameter int LEN_ALIGN  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  reg_sel_e    sel,
    input  logic [31:0] wdata,
    output xfer_req_t   cfg
);
    localparam logic [LEN_W-1:0]  ALIGN_MASK = LEN_W'((1 << LEN_ALIGN) - 1);
    localparam logic [FLAG_W-1:0] FLAG_KEEP  = HAS_REPEAT ? 3'b111 : 3'b110;

    logic [LEN_W-1:0]  xlen_q, ylen_q;
    logic [31:0]       ss_q, ds_q, src_q, dst_q;
    logic [FLAG_W-1:0] flg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xlen_q <= ALIGN_MASK;
            ylen_q <= '0;
            ss_q   <= '0;
            ds_q   <= '0;
            flg_q  <= '0;
        end else if (wr) begin
            case (sel)
                SEL_XLEN:    xlen_q <= wdata[LEN_W-1:0] | ALIGN_MASK;
                SEL_YLEN:    ylen_q <= wdata[LEN_W-1:0];
                SEL_SSTRIDE: ss_q   <= wdata;
                SEL_DSTRIDE: ds_q   <= wdata;
                SEL_FLAGS:   flg_q  <= wdata[FLAG_W-1:0] & FLAG_KEEP;
                default: ;
            endcase
        end
    end

    generate
        if (SRC_MM) begin : g_src_mm
            always_ff @(posedge clk) begin
                if (rst)                        src_q <= '0;
                else if (wr && sel == SEL_SRC)  src_q <= wdata;
            end
        end else begin : g_src_stream
            assign src_q = '0;
        end

        if (DST_MM) begin : g_dst_mm
            always_ff @(posedge clk) begin
                if (rst)                        dst_q <= '0;
                else if (wr && sel == SEL_DST)  dst_q <= wdata;
            end
        end else begin : g_dst_stream
            assign dst_q = '0;
        end
    endgenerate

    always_comb begin
        cfg.src        = src_q;
        cfg.dst        = dst_q;
        cfg.xlen       = 32'(xlen_q);
        cfg.ylen       = 32'(ylen_q);
        cfg.src_stride = ss_q;
        cfg.dst_stride = ds_q;
        cfg.flags      = flg_q;
    end

    // R10: the forced-one low bits never read back clear
    p_align_ones_r10: assert property (@(posedge clk) disable iff (rst)
        wr && sel == SEL_XLEN |=> (xlen_q & ALIGN_MASK) == ALIGN_MASK);

endmodule

// File: rtl/dreq_issue.sv
module dreq_issue
    import dreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_req_t         cfg,
    input  logic              req_ready,
    input  logic              cpl_acc,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              req_valid,
    output xfer_req_t         req,
    output logic [ID_W-1:0]   req_id,
    output logic [ID_W-1:0]   next_id,
    output logic              start_busy,
    output logic [NUM_ID-1:0] rpt_en
);
    logic [NUM_ID-1:0] out_q, out_d, rpt_d;
    logic              take;

    assign start_busy = req_valid | out_q[next_id];
    assign take       = start & ~start_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req       <= '0;
            req_id    <= '0;
            next_id   <= '0;
        end else if (take) begin
            req_valid <= 1'b1;
            req       <= cfg;
            req_id    <= next_id;
            next_id   <= id_next(next_id);
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_ID; i++) begin
            if (take && next_id == ID_W'(i)) begin
                out_d[i] = 1'b1;
                rpt_d[i] = cfg.flags[FLG_REPORT];
            end else begin
                out_d[i] = (cpl_acc && cpl_id == ID_W'(i)) ? 1'b0 : out_q[i];
                rpt_d[i] = rpt_en[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            rpt_en <= '0;
        end else begin
            out_q  <= out_d;
            rpt_en <= rpt_d;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_id) && $stable(req));

    p_id_step_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> next_id == $past(next_id) + 1'b1);

    p_marks_r2: assert property (@(posedge clk) disable iff (rst)
        take |=> out_q[$past(next_id)]);

    p_refused_r2: assert property (@(posedge clk) disable iff (rst)
        start && start_busy |=> $stable(next_id));

endmodule

// File: rtl/dreq_partq.sv
module dreq_partq
    import dreq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  early_rec_t din,
    input  logic       pop,
    output early_rec_t head,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    early_rec_t        slots [DEPTH];
    logic [PW-1:0]     wp, rp;
    logic [CW-1:0]     cnt;
    logic              do_push, do_pop;

    function automatic logic [PW-1:0] ptr_adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_pop  = pop & ~empty;
    assign do_push = push & ~full;
    assign head    = slots[rp];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)                                slots[s] <= '0;
                else if (do_push && wp == PW'(s))       slots[s] <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= ptr_adv(wp);
            if (do_pop)  rp <= ptr_adv(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    p_pop_r5: assert property (@(posedge clk) disable iff (rst)
        do_pop && !do_push |=> cnt == $past(cnt) - 1'b1);

    p_push_r5: assert property (@(posedge clk) disable iff (rst)
        do_push && !do_pop |=> !empty);

endmodule

// File: rtl/dreq_status.sv
module dreq_status
    import dreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpl_acc,
    input  logic [ID_W-1:0]   cpl_id,
    input  logic [NUM_ID-1:0] done_clr,
    input  logic              pend_clr,
    input  logic              en_wr,
    input  logic              en_val,
    output logic [NUM_ID-1:0] done_q,
    output logic              pend,
    output logic              en,
    output logic              irq
);
    logic [NUM_ID-1:0] done_d;

    always_comb begin
        for (int i = 0; i < NUM_ID; i++) begin
            if (cpl_acc && cpl_id == ID_W'(i)) done_d[i] = 1'b1;
            else if (done_clr[i])              done_d[i] = 1'b0;
            else                               done_d[i] = done_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= '0;
            pend   <= 1'b0;
            en     <= 1'b0;
        end else begin
            done_q <= done_d;
            if (cpl_acc)       pend <= 1'b1;
            else if (pend_clr) pend <= 1'b0;
            if (en_wr)         en   <= en_val;
        end
    end

    assign irq = pend & en;

    p_done_set_r4: assert property (@(posedge clk) disable iff (rst)
        cpl_acc |=> done_q[$past(cpl_id)]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        !cpl_acc |=> (done_q & $past(done_clr)) == '0);

    p_pend_set_r12: assert property (@(posedge clk) disable iff (rst)
        cpl_acc |=> pend);

    p_pend_hold_r12: assert property (@(posedge clk) disable iff (rst)
        pend && !pend_clr |=> pend);

endmodule

// File: rtl/dreq_ctl.sv
module dreq_ctl
    import dreq_pkg::*;
#(
    parameter bit HAS_REPEAT = 1'b1,
    parameter bit SRC_MM     = 1'b1,
    parameter bit DST_MM     = 1'b0,
    parameter int LEN_W      = 24,
    parameter int LEN_ALIGN  = 2,
    parameter int RPT_DEPTH  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        req_valid,
    input  logic        req_ready,
    output logic [4:0]  req_id,
    output logic [31:0] req_src,
    output logic [31:0] req_dst,
    output logic [31:0] req_xlen,
    output logic [31:0] req_ylen,
    output logic [31:0] req_src_stride,
    output logic [31:0] req_dst_stride,
    output logic [2:0]  req_flags,
    input  logic        cpl_valid,
    output logic        cpl_ready,
    input  logic [4:0]  cpl_id,
    input  logic        cpl_early,
    input  logic [31:0] cpl_len,
    output logic        irq
);
    reg_sel_e          sel;
    xfer_req_t         cfg, req;
    logic [ID_W-1:0]   next_id;
    logic              start_busy, start;
    logic [NUM_ID-1:0] rpt_en, done_q, done_clr;
    logic              pend, en;
    logic              rpt_hit, cpl_acc, q_push, q_pop, q_empty, q_full;
    early_rec_t        q_head, q_in;

    assign sel   = decode_sel(reg_addr);
    assign start = reg_wr && sel == SEL_START && reg_wdata[0];

    dreq_cfg #(
        .HAS_REPEAT(HAS_REPEAT), .SRC_MM(SRC_MM), .DST_MM(DST_MM),
        .LEN_W(LEN_W), .LEN_ALIGN(LEN_ALIGN)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(sel), .wdata(reg_wdata), .cfg(cfg)
    );

    dreq_issue u_issue (
        .clk(clk), .rst(rst), .start(start), .cfg(cfg), .req_ready(req_ready),
        .cpl_acc(cpl_acc), .cpl_id(cpl_id), .req_valid(req_valid), .req(req),
        .req_id(req_id), .next_id(next_id), .start_busy(start_busy), .rpt_en(rpt_en)
    );

    // reportable early end stalls only when the queue has no room
    assign rpt_hit   = cpl_early & rpt_en[cpl_id];
    assign cpl_ready = ~(rpt_hit & q_full);
    assign cpl_acc   = cpl_valid & cpl_ready;
    assign q_push    = cpl_acc & rpt_hit;
    assign q_pop     = reg_rd && sel == SEL_EID;
    assign q_in      = '{id: cpl_id, len: cpl_len};

    dreq_partq #(.DEPTH(RPT_DEPTH)) u_q (
        .clk(clk), .rst(rst), .push(q_push), .din(q_in), .pop(q_pop),
        .head(q_head), .empty(q_empty), .full(q_full)
    );

    always_comb begin
        done_clr = '0;
        if (reg_wr && sel == SEL_DONE)
            done_clr[NUM_ID-2:0] = reg_wdata[NUM_ID-2:0];
        if (reg_wr && sel == SEL_ID_STAT)
            done_clr[NUM_ID-1] = reg_wdata[STAT_DONE_TOP_BIT];
    end

    dreq_status u_stat (
        .clk(clk), .rst(rst), .cpl_acc(cpl_acc), .cpl_id(cpl_id),
        .done_clr(done_clr), .pend_clr(reg_wr && sel == SEL_IRQ_PEND && reg_wdata[0]),
        .en_wr(reg_wr && sel == SEL_IRQ_EN), .en_val(reg_wdata[0]),
        .done_q(done_q), .pend(pend), .en(en), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_IRQ_PEND: reg_rdata[0] = pend;
            SEL_IRQ_EN:   reg_rdata[0] = en;
            SEL_ID_STAT: begin
                reg_rdata[ID_W-1:0]         = next_id;
                reg_rdata[STAT_DONE_TOP_BIT] = done_q[NUM_ID-1];
            end
            SEL_START:    reg_rdata[0] = start_busy;
            SEL_FLAGS:    reg_rdata[FLAG_W-1:0] = cfg.flags;
            SEL_DST:      reg_rdata = cfg.dst;
            SEL_SRC:      reg_rdata = cfg.src;
            SEL_XLEN:     reg_rdata = cfg.xlen;
            SEL_YLEN:     reg_rdata = cfg.ylen;
            SEL_DSTRIDE:  reg_rdata = cfg.dst_stride;
            SEL_SSTRIDE:  reg_rdata = cfg.src_stride;
            SEL_DONE: begin
                reg_rdata[NUM_ID-2:0]  = done_q[NUM_ID-2:0];
                reg_rdata[DONE_QNZ_BIT] = ~q_empty;
            end
            SEL_ELEN:     reg_rdata = q_empty ? '0 : q_head.len;
            SEL_EID:      reg_rdata[ID_W-1:0] = q_empty ? '0 : q_head.id;
            default: ;
        endcase
    end

    assign req_src        = req.src;
    assign req_dst        = req.dst;
    assign req_xlen       = req.xlen;
    assign req_ylen       = req.ylen;
    assign req_src_stride = req.src_stride;
    assign req_dst_stride = req.dst_stride;
    assign req_flags      = req.flags;

    // R7: a stalled report is never taken into the queue
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |-> !q_push);

endmodule

// File: tb/dreq_ctl_test.sv
module dreq_ctl_test;
    localparam int LEN_W = 24;
    localparam int LEN_ALIGN = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 0, reg_rd = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic req_valid, req_ready = 0;
    logic [4:0] req_id;
    logic [31:0] req_src, req_dst, req_xlen, req_ylen, req_ss, req_ds;
    logic [2:0] req_flags;
    logic cpl_valid = 0, cpl_ready, cpl_early = 0, irq;
    logic [4:0] cpl_id = '0;
    logic [31:0] cpl_len = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dreq_ctl #(.HAS_REPEAT(1'b1), .SRC_MM(1'b1), .DST_MM(1'b0),
               .LEN_W(LEN_W), .LEN_ALIGN(LEN_ALIGN), .RPT_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_id(req_id), .req_src(req_src), .req_dst(req_dst),
        .req_xlen(req_xlen), .req_ylen(req_ylen), .req_src_stride(req_ss),
        .req_dst_stride(req_ds), .req_flags(req_flags), .cpl_valid(cpl_valid),
        .cpl_ready(cpl_ready), .cpl_id(cpl_id), .cpl_early(cpl_early),
        .cpl_len(cpl_len), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_src, m_dst, m_xlen, m_ylen, m_ss, m_ds;
    logic [2:0]  m_flags;
    logic [31:0] m_out, m_done, m_pe;
    int          m_next;
    bit          m_pend, m_en, m_slot_v;
    int          m_slot_id;
    logic [31:0] m_slot_xlen;
    logic [2:0]  m_slot_flags;
    int          q_id[$];
    logic [31:0] q_len[$];

    task automatic m_reset();
        m_src = 0; m_dst = 0; m_xlen = 32'h3; m_ylen = 0; m_ss = 0; m_ds = 0;
        m_flags = 0; m_out = 0; m_done = 0; m_pe = 0; m_next = 0;
        m_pend = 0; m_en = 0; m_slot_v = 0; m_slot_id = 0;
        m_slot_xlen = 0; m_slot_flags = 0;
        q_id.delete(); q_len.delete();
    endtask

    function automatic bit m_cpl_ready();
        return !(cpl_early && m_pe[cpl_id] && q_id.size() == 4);
    endfunction

    function automatic logic [31:0] m_rdata(input logic [11:0] a);
        logic [31:0] r = 0;
        case (a)
            12'h410: r[0] = m_pend;
            12'h414: r[0] = m_en;
            12'h420: begin r[4:0] = m_next[4:0]; r[16] = m_done[31]; end
            12'h424: r[0] = m_slot_v | m_out[m_next];
            12'h428: r[2:0] = m_flags;
            12'h42C: r = m_dst;
            12'h430: r = m_src;
            12'h434: r = m_xlen;
            12'h438: r = m_ylen;
            12'h43C: r = m_ds;
            12'h440: r = m_ss;
            12'h444: begin r[30:0] = m_done[30:0]; r[31] = (q_id.size() != 0); end
            12'h44C: r = (q_id.size() != 0) ? q_len[0] : 0;
            12'h450: r = (q_id.size() != 0) ? q_id[0] : 0;
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic m_step();
        bit acc, push, pop, take;
        acc  = cpl_valid && m_cpl_ready();
        push = acc && cpl_early && m_pe[cpl_id];
        pop  = reg_rd && reg_addr == 12'h450 && q_id.size() != 0;
        take = reg_wr && reg_addr == 12'h424 && reg_wdata[0] && !m_slot_v && !m_out[m_next];
        if (m_slot_v && req_ready) m_slot_v = 0;
        if (take) begin
            m_slot_v = 1; m_slot_id = m_next; m_slot_xlen = m_xlen; m_slot_flags = m_flags;
            m_out[m_next] = 1; m_pe[m_next] = m_flags[2]; m_next = (m_next + 1) % 32;
        end
        if (reg_wr) begin
            case (reg_addr)
                12'h444: m_done[30:0] = m_done[30:0] & ~reg_wdata[30:0];
                12'h420: if (reg_wdata[16]) m_done[31] = 0;
                12'h410: if (reg_wdata[0]) m_pend = 0;
                12'h414: m_en = reg_wdata[0];
                12'h428: m_flags = reg_wdata[2:0];
                12'h430: m_src = reg_wdata;
                12'h434: m_xlen = (reg_wdata | 32'h3) & 32'h00FF_FFFF;
                12'h438: m_ylen = reg_wdata & 32'h00FF_FFFF;
                12'h43C: m_ds = reg_wdata;
                12'h440: m_ss = reg_wdata;
                default: ;
            endcase
        end
        if (acc) begin
            m_out[cpl_id] = 0; m_done[cpl_id] = 1; m_pend = 1;
        end
        if (pop) begin void'(q_id.pop_front()); void'(q_len.pop_front()); end
        if (push) begin q_id.push_back(int'(cpl_id)); q_len.push_back(cpl_len); end
    endtask

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag);
        #1;
        chk("R12", "irq", 32'(irq), 32'(m_pend & m_en));
        chk("R3", "req_valid", 32'(req_valid), 32'(m_slot_v));
        if (m_slot_v) begin
            chk("R2", "req_id", 32'(req_id), 32'(m_slot_id));
            chk("R2", "req_xlen", req_xlen, m_slot_xlen);
            chk("R2", "req_flags", 32'(req_flags), 32'(m_slot_flags));
        end
        chk("R7", "cpl_ready", 32'(cpl_ready), 32'(m_cpl_ready()));
        chk(tag, "rdata", reg_rdata, m_rdata(reg_addr));
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    task automatic wreg(input logic [11:0] a, input logic [31:0] d, input string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(tag); reg_wr = 0;
    endtask

    task automatic rreg(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_rd = 1; reg_addr = a; #1;
        chk(tag, "read", reg_rdata, exp);
        cyc(tag); reg_rd = 0;
    endtask

    task automatic report(input int id, input bit early, input logic [31:0] len, input string tag);
        cpl_valid = 1; cpl_id = 5'(id); cpl_early = early; cpl_len = len;
        cyc(tag);
        cpl_valid = 0; cpl_early = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        rreg(12'h420, 32'h0, "R1");
        rreg(12'h444, 32'h0, "R1");
        rreg(12'h424, 32'h0, "R1");
        rreg(12'h434, 32'h3, "R1");

        // R10 length readback
        wreg(12'h434, 32'h0, "R10");
        rreg(12'h434, 32'h3, "R10");
        wreg(12'h434, 32'hFFFF_FFFF, "R10");
        rreg(12'h434, 32'h00FF_FFFF, "R10");
        wreg(12'h438, 32'hFFFF_FFFF, "R10");
        rreg(12'h438, 32'h00FF_FFFF, "R10");

        // R11 memory-mapped sides
        wreg(12'h430, 32'hFFFF_FFFF, "R11");
        rreg(12'h430, 32'hFFFF_FFFF, "R11");
        wreg(12'h42C, 32'hFFFF_FFFF, "R11");
        rreg(12'h42C, 32'h0, "R11");

        // R9 flags
        wreg(12'h428, 32'hFF, "R9");
        rreg(12'h428, 32'h7, "R9");

        // R13 unmapped / unaligned
        wreg(12'h404, 32'hFFFF_FFFF, "R13");
        rreg(12'h404, 32'h0, "R13");
        wreg(12'h435, 32'h0, "R13");
        rreg(12'h434, 32'h00FF_FFFF, "R13");

        // R2/R3 start held off by mover
        wreg(12'h414, 32'h1, "R12");
        wreg(12'h434, 32'h10, "R2");
        wreg(12'h428, 32'h4, "R9");
        wreg(12'h424, 32'h1, "R2");
        cyc("R3"); cyc("R3");
        wreg(12'h424, 32'h1, "R2");        // refused: slot occupied
        rreg(12'h420, 32'h1, "R2");
        rreg(12'h424, 32'h1, "R2");
        req_ready = 1; cyc("R3"); req_ready = 0;
        rreg(12'h424, 32'h0, "R2");

        // R4/R12 normal completion
        report(0, 0, 0, "R4");
        rreg(12'h444, 32'h1, "R4");
        rreg(12'h410, 32'h1, "R12");
        wreg(12'h410, 32'h1, "R12");
        rreg(12'h410, 32'h0, "R12");
        wreg(12'h444, 32'h1, "R4");
        rreg(12'h444, 32'h0, "R4");

        // R5/R6/R7/R8 early-end queue
        req_ready = 1;
        for (int k = 0; k < 5; k++) begin
            wreg(12'h424, 32'h1, "R2"); cyc("R3");
        end
        wreg(12'h428, 32'h0, "R8");
        wreg(12'h424, 32'h1, "R2"); cyc("R3");           // ID 6 without reporting
        for (int k = 1; k <= 4; k++) report(k, 1, 32'(k * 100), "R5");
        rreg(12'h444, 32'h8000_001E, "R6");
        cpl_valid = 1; cpl_id = 5; cpl_early = 1; cpl_len = 32'h55; #1;
        chk("R7", "stall on full", 32'(cpl_ready), 32'h0);
        cyc("R7");
        cpl_early = 0; #1;
        chk("R7", "normal report accepted", 32'(cpl_ready), 32'h1);
        cyc("R7"); cpl_valid = 0;
        report(6, 1, 32'h77, "R8");
        rreg(12'h44C, 32'd100, "R5");
        for (int k = 1; k <= 4; k++) begin
            rreg(12'h44C, 32'(k * 100), "R5");
            rreg(12'h450, 32'(k), "R5");
        end
        rreg(12'h444, 32'h0000_007E, "R6");
        rreg(12'h450, 32'h0, "R8");

        // R2 wrap and outstanding-ID refusal, R4 for ID 31
        wreg(12'h444, 32'h7FFF_FFFF, "R4");
        for (int k = 0; k < 32; k++) begin
            wreg(12'h424, 32'h1, "R2"); cyc("R3");
        end
        wreg(12'h424, 32'h1, "R2");                       // ID 7 still outstanding
        rreg(12'h424, 32'h1, "R2");
        rreg(12'h420, 32'h7, "R2");
        for (int k = 0; k < 32; k++) report(k, 0, 0, "R4");
        rreg(12'h420, 32'h0001_0007, "R4");
        rreg(12'h444, 32'h7FFF_FFFF, "R4");
        wreg(12'h420, 32'h0001_0000, "R4");
        rreg(12'h420, 32'h7, "R4");
        rreg(12'h424, 32'h0, "R2");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule